// File: doc/BRIEF.md
# Packed Sign Strip and Restore Unit

This block wraps an unsigned arithmetic core that works on packed lanes. A 32-bit input word carries sign-magnitude operands in one of three packings: eight 4-bit lanes, four 8-bit lanes or two 16-bit lanes. In signed mode the unit clears the top bit of every operand lane and sends the resulting magnitude word to the core. At the same clock edge it records the operand signs together with the lane width and the signed flag.

The recorded signs travel through a short shift register. The core takes a different number of cycles for each lane width, so the sign pipeline is tapped at the depth that matches the width of each operation. When an operation reaches its tap, the unit takes the core's result word from that cycle. Each result lane is twice the operand width and holds the product of two neighbouring operand lanes. For each result lane the unit writes the XOR of the two operand signs into the lane's top bit and registers the corrected word. In unsigned mode both directions pass the data through unchanged.

Top module: `sign_restore_unit`

## Requirements
- R1: `magWord` and `magValid` update at the clock edge that samples `inValid` high. `magValid` is high for exactly the cycle after each accepted input, and `magWord` holds its value while no input is accepted.
- R2: In signed mode (`signedMode` = 1) the magnitude word equals the input with each operand lane's top bit cleared. These are bits 31 and 15 for 16-bit lanes, bits 31, 23, 15 and 7 for 8-bit lanes, and every bit 4k+3 for 4-bit lanes. For example, 0x92378543 in 16-bit mode becomes 0x12370543.
- R3: In unsigned mode (`signedMode` = 0) the magnitude word equals the input word.
- R4: `widthSel` = 00 selects 4-bit lanes, 10 selects 8-bit lanes and 11 selects 16-bit lanes. The code 01 behaves like 00.
- R5: With default parameters, an operation accepted at edge E0 takes `coreResult` in the cycle after edge E0+L, where L is 1, 3 and 5 for 4-, 8- and 16-bit lanes. The corrected word appears on `resultWord` with `outValid` high after edge E0+L+1.
- R6: In signed mode, result lane k is bits [2W(k+1)-1 : 2Wk] for operand width W. It takes its lower bits from `coreResult`, and its top bit is set to the XOR of the signs of operand lanes 2k and 2k+1.
- R7: In signed mode, a result lane whose lower 2W-1 bits from the core are all zero gets a top bit of 0, whatever the operand signs.
- R8: For an unsigned operation, `resultWord` equals `coreResult` from the tap cycle, all 32 bits.
- R9: In a cycle after which no operation reaches its tap, `outValid` is low and `resultWord` keeps its value. After reset `magWord`, `resultWord`, `magValid` and `outValid` are all zero.
- R10: A new operation may be accepted every cycle, whatever the widths. If two operations reach their taps in the same cycle, the one with the longer latency is restored and the other one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is present this cycle |
| inWord | input | 32 | Packed sign-magnitude operand lanes |
| widthSel | input | 2 | Lane width code (00 = 4-bit, 10 = 8-bit, 11 = 16-bit) |
| signedMode | input | 1 | 1 = lanes are sign-magnitude, 0 = unsigned |
| coreResult | input | 32 | Unsigned result word from the arithmetic core |
| magValid | output | 1 | Magnitude word updated at the last edge |
| magWord | output | 32 | Input with lane sign bits cleared |
| outValid | output | 1 | Corrected result updated at the last edge |
| resultWord | output | 32 | Core result with lane signs written back |

## Verification
Stripping and restoring can happen in the same cycle. So can two restores, when a slow 16-bit operation and a later 8-bit operation reach their taps together. The bench issues 4-bit operations back to back, so that each cycle accepts a new input while an older one is being restored, and it checks both results. It then issues a 16-bit operation and, two cycles later, an 8-bit operation whose signs would give a different top bit. The single restored word must carry the sign of the older 16-bit operation.

// File: rtl/sign_restore_pkg.sv
package sign_restore_pkg;

  typedef enum logic [1:0] {
    LANE4  = 2'd0,
    LANE8  = 2'd1,
    LANE16 = 2'd2
  } laneW_e;

  // Code 11 is 16-bit, 10 is 8-bit, anything with the high bit clear is 4-bit.
  function automatic laneW_e decodeWidth(input logic [1:0] code);
    if (!code[1])     return LANE4;
    else if (code[0]) return LANE16;
    else              return LANE8;
  endfunction

  typedef struct packed {
    logic   capture;      // accept input this cycle
    logic   stripSigned;  // clear lane sign bits on the way in
    laneW_e stripWidth;   // lane width of the incoming word
    logic   tapHit;       // some operation reaches its tap this cycle
    logic [2:0] tapSel;   // one-hot: which width tap wins (bit0=4, bit1=8, bit2=16)
    logic   tapSigned;    // winning operation was signed
  } ctrl_t;

endpackage

// File: rtl/sign_restore_ctrl.sv
module sign_restore_ctrl
  import sign_restore_pkg::*;
#(
  parameter int LAT4  = 1,
  parameter int LAT8  = 3,
  parameter int LAT16 = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] widthSel,
  input  logic       signedMode,
  output ctrl_t      ctrlBus,
  output logic       magValid,
  output logic       outValid
);

  localparam int DEPTH = (LAT16 > LAT8) ? ((LAT16 > LAT4) ? LAT16 : LAT4)
                                        : ((LAT8  > LAT4) ? LAT8  : LAT4);

  logic   tagVld [0:DEPTH];
  laneW_e tagW   [0:DEPTH];
  logic   tagS   [0:DEPTH];

  laneW_e decoded;
  logic   hit4, hit8, hit16;

  always_comb begin
    decoded = decodeWidth(widthSel);
    hit4    = tagVld[LAT4]  && (tagW[LAT4]  == LANE4);
    hit8    = tagVld[LAT8]  && (tagW[LAT8]  == LANE8);
    hit16   = tagVld[LAT16] && (tagW[LAT16] == LANE16);

    ctrlBus.capture     = inValid;
    ctrlBus.stripSigned = signedMode;
    ctrlBus.stripWidth  = decoded;
    ctrlBus.tapHit      = hit4 | hit8 | hit16;

    // Oldest (longest latency) operation wins a collision.
    if (hit16) begin
      ctrlBus.tapSel    = 3'b100;
      ctrlBus.tapSigned = tagS[LAT16];
    end else if (hit8) begin
      ctrlBus.tapSel    = 3'b010;
      ctrlBus.tapSigned = tagS[LAT8];
    end else if (hit4) begin
      ctrlBus.tapSel    = 3'b001;
      ctrlBus.tapSigned = tagS[LAT4];
    end else begin
      ctrlBus.tapSel    = 3'b000;
      ctrlBus.tapSigned = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= DEPTH; i++) begin
        tagVld[i] <= 1'b0;
        tagW[i]   <= LANE4;
        tagS[i]   <= 1'b0;
      end
      magValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      tagVld[0] <= inValid;
      tagW[0]   <= decoded;
      tagS[0]   <= signedMode;
      for (int i = 1; i <= DEPTH; i++) begin
        tagVld[i] <= tagVld[i-1];
        tagW[i]   <= tagW[i-1];
        tagS[i]   <= tagS[i-1];
      end
      magValid <= inValid;
      outValid <= hit4 | hit8 | hit16;
    end
  end

endmodule

// File: rtl/sign_restore_dp.sv
module sign_restore_dp
  import sign_restore_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT4   = 1,
  parameter int LAT8   = 3,
  parameter int LAT16  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrlBus,
  input  logic [DATA_W-1:0] inWord,
  input  logic [DATA_W-1:0] coreResult,
  output logic [DATA_W-1:0] magWord,
  output logic [DATA_W-1:0] resultWord
);

  localparam int NSIGN = DATA_W / 4;
  localparam int DEPTH = (LAT16 > LAT8) ? ((LAT16 > LAT4) ? LAT16 : LAT4)
                                        : ((LAT8  > LAT4) ? LAT8  : LAT4);

  logic [NSIGN-1:0] signPipe [0:DEPTH];

  // One strip/extract/restore variant per lane width.
  for (genvar g = 0; g < 3; g++) begin : gen_w
    localparam int OPW = 4 << g;
    localparam int NL  = DATA_W / OPW;
    localparam int TAP = (g == 0) ? LAT4 : ((g == 1) ? LAT8 : LAT16);

    logic [DATA_W-1:0] stripG;
    logic [DATA_W-1:0] restG;
    logic [NSIGN-1:0]  signG;

    always_comb begin
      stripG = inWord;
      signG  = '0;
      for (int k = 0; k < NL; k++) begin
        signG[k]               = inWord[k*OPW + OPW - 1];
        stripG[k*OPW + OPW - 1] = 1'b0;
      end
    end

    always_comb begin
      restG = coreResult;
      for (int k = 0; k < NL/2; k++) begin
        restG[k*2*OPW + 2*OPW - 1] =
          (signPipe[TAP][2*k] ^ signPipe[TAP][2*k+1]) &
          (|coreResult[k*2*OPW +: 2*OPW-1]);
      end
    end
  end

  logic [DATA_W-1:0] stripSel;
  logic [NSIGN-1:0]  signSel;
  logic [DATA_W-1:0] restSel;

  always_comb begin
    case (ctrlBus.stripWidth)
      LANE16:  begin stripSel = gen_w[2].stripG; signSel = gen_w[2].signG; end
      LANE8:   begin stripSel = gen_w[1].stripG; signSel = gen_w[1].signG; end
      default: begin stripSel = gen_w[0].stripG; signSel = gen_w[0].signG; end
    endcase
    if (!ctrlBus.stripSigned) begin
      stripSel = inWord;
      signSel  = '0;
    end

    if (ctrlBus.tapSel[2])      restSel = gen_w[2].restG;
    else if (ctrlBus.tapSel[1]) restSel = gen_w[1].restG;
    else                        restSel = gen_w[0].restG;
    if (!ctrlBus.tapSigned) restSel = coreResult;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magWord    <= '0;
      resultWord <= '0;
      for (int i = 0; i <= DEPTH; i++) signPipe[i] <= '0;
    end else begin
      if (ctrlBus.capture) magWord <= stripSel;
      signPipe[0] <= ctrlBus.capture ? signSel : '0;
      for (int i = 1; i <= DEPTH; i++) signPipe[i] <= signPipe[i-1];
      if (ctrlBus.tapHit) resultWord <= restSel;
    end
  end

endmodule

// File: rtl/sign_restore_unit.sv
module sign_restore_unit
  import sign_restore_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT4   = 1,
  parameter int LAT8   = 3,
  parameter int LAT16  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inWord,
  input  logic [1:0]        widthSel,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] coreResult,
  output logic              magValid,
  output logic [DATA_W-1:0] magWord,
  output logic              outValid,
  output logic [DATA_W-1:0] resultWord
);

  ctrl_t ctrlBus;

  sign_restore_ctrl #(.LAT4(LAT4), .LAT8(LAT8), .LAT16(LAT16)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .widthSel   (widthSel),
    .signedMode (signedMode),
    .ctrlBus    (ctrlBus),
    .magValid   (magValid),
    .outValid   (outValid)
  );

  sign_restore_dp #(.DATA_W(DATA_W), .LAT4(LAT4), .LAT8(LAT8), .LAT16(LAT16)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlBus    (ctrlBus),
    .inWord     (inWord),
    .coreResult (coreResult),
    .magWord    (magWord),
    .resultWord (resultWord)
  );

endmodule

// File: rtl/sign_restore_chk.sv
module sign_restore_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inWord,
  input logic [1:0]        widthSel,
  input logic              signedMode,
  input logic [DATA_W-1:0] coreResult,
  input logic              magValid,
  input logic [DATA_W-1:0] magWord,
  input logic              outValid,
  input logic [DATA_W-1:0] resultWord,
  input logic              tapHit,
  input logic [2:0]        tapSel,
  input logic              tapSigned
);

  AST_MAG_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> magValid); // R1
  AST_MAG_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !magValid); // R1
  AST_STRIP_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && signedMode && widthSel == 2'b11) |=> (!magWord[DATA_W-1] && !magWord[DATA_W/2-1])); // R2
  AST_UNSIGNED_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !signedMode) |=> (magWord == $past(inWord))); // R3
  AST_OUT_FOLLOWS_TAP: assert property (@(posedge clk) disable iff (!rstN) tapHit |=> outValid); // R5
  AST_UNSIGNED_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (tapHit && !tapSigned) |=> (resultWord == $past(coreResult))); // R8
  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (tapHit && tapSigned && tapSel[2] && coreResult[DATA_W-2:0] == '0) |=> (resultWord == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tapHit |=> (!outValid && $stable(resultWord))); // R9
  AST_SINGLE_TAP: assert property (@(posedge clk) disable iff (!rstN) $onehot0(tapSel)); // R10

endmodule

bind sign_restore_unit sign_restore_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inWord     (inWord),
  .widthSel   (widthSel),
  .signedMode (signedMode),
  .coreResult (coreResult),
  .magValid   (magValid),
  .magWord    (magWord),
  .outValid   (outValid),
  .resultWord (resultWord),
  .tapHit     (ctrlBus.tapHit),
  .tapSel     (ctrlBus.tapSel),
  .tapSigned  (ctrlBus.tapSigned)
);

// File: tb/sign_restore_unit_bench.sv
`timescale 1ns/1ps
module sign_restore_unit_bench;

  localparam logic [31:0] IDLE_CORE = 32'h5A5A_5A5A;

  typedef struct packed {
    logic [1:0]  w;
    logic        sg;
    logic [31:0] din;
    logic [31:0] mag;
    logic [31:0] core;
    logic [31:0] res;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b1, 32'h9237_8543, 32'h1237_0543, 32'h8000_1234, 32'h0000_1234}, // R2 R6 like signs
    '{2'b11, 1'b1, 32'h1234_8543, 32'h1234_0543, 32'h0000_0ABC, 32'h8000_0ABC}, // R6 unlike signs
    '{2'b11, 1'b1, 32'h8000_0005, 32'h0000_0005, 32'h0000_0000, 32'h0000_0000}, // R7 zero
    '{2'b10, 1'b1, 32'h8A05_FF7F, 32'h0A05_7F7F, 32'h0123_0456, 32'h8123_8456}, // R6 8-bit
    '{2'b10, 1'b1, 32'h8080_0180, 32'h0000_0100, 32'hFFFF_0000, 32'h7FFF_0000}, // R6 R7
    '{2'b00, 1'b1, 32'h9F3A_C851, 32'h1732_4051, 32'h8A15_8023, 32'h0A95_0023}, // R6 R7 4-bit
    '{2'b01, 1'b1, 32'h0000_0008, 32'h0000_0000, 32'h0000_0011, 32'h0000_0091}, // R4 code 01
    '{2'b11, 1'b0, 32'h9237_8543, 32'h9237_8543, 32'h8000_0000, 32'h8000_0000}, // R3 R8
    '{2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R3 R8
    '{2'b00, 1'b0, 32'h8888_8888, 32'h8888_8888, 32'h0000_0080, 32'h0000_0080}  // R3 R8
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic [1:0]  widthSel = 2'b00;
  logic        signedMode = 1'b0;
  logic [31:0] coreResult = IDLE_CORE;
  logic        magValid, outValid;
  logic [31:0] magWord, resultWord;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sign_restore_unit u_sign_restore_unit (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inWord     (inWord),
    .widthSel   (widthSel),
    .signedMode (signedMode),
    .coreResult (coreResult),
    .magValid   (magValid),
    .magWord    (magWord),
    .outValid   (outValid),
    .resultWord (resultWord)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int latOf(input logic [1:0] w);
    if (!w[1]) return 1;
    return w[0] ? 5 : 3;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset outValid", {31'd0, outValid}, 32'd0);
    check("R9 reset resultWord", resultWord, 32'd0);
    check("R1 reset magValid", {31'd0, magValid}, 32'd0);
    check("R1 reset magWord", magWord, 32'd0);
    rstN = 1'b1;
    tick();

    // Table walk: one isolated operation per row
    for (int v = 0; v < NV; v++) begin
      logic [31:0] prevRes;
      inValid    = 1'b1;
      inWord     = VECS[v].din;
      widthSel   = VECS[v].w;
      signedMode = VECS[v].sg;
      tick();
      inValid = 1'b0;
      inWord  = 32'hFFFF_FFFF;
      check("R1 magValid", {31'd0, magValid}, 32'd1);
      check("R1/R2/R3/R4 magWord", magWord, VECS[v].mag);
      for (int i = 0; i < latOf(VECS[v].w); i++) begin
        tick();
        check("R1 magWord hold", magWord, VECS[v].mag);
      end
      check("R5 no early outValid", {31'd0, outValid}, 32'd0);
      coreResult = VECS[v].core;
      tick();
      coreResult = IDLE_CORE;
      check("R5 outValid", {31'd0, outValid}, 32'd1);
      check("R5/R6/R7/R8 resultWord", resultWord, VECS[v].res);
      prevRes = resultWord;
      tick();
      check("R9 idle outValid", {31'd0, outValid}, 32'd0);
      check("R9 idle hold", resultWord, prevRes);
      repeat (6) tick();
    end

    // R10 back-to-back 4-bit signed operations
    signedMode = 1'b1;
    widthSel   = 2'b00;
    inValid    = 1'b1;
    inWord     = 32'h0000_0008;
    tick();                       // after E0: X captured
    inWord     = 32'h0000_0000;
    tick();                       // after E1: Y captured, X at its tap
    inValid    = 1'b0;
    coreResult = 32'h0000_0011;
    tick();                       // after E2: X restored, Y at its tap
    check("R10 back-to-back first", resultWord, 32'h0000_0091);
    check("R10 back-to-back first valid", {31'd0, outValid}, 32'd1);
    tick();                       // after E3: Y restored
    coreResult = IDLE_CORE;
    check("R10 back-to-back second", resultWord, 32'h0000_0011);
    check("R10 back-to-back second valid", {31'd0, outValid}, 32'd1);
    repeat (6) tick();

    // R10 collision: 16-bit op and later 8-bit op reach taps together
    inValid    = 1'b1;
    widthSel   = 2'b11;
    inWord     = 32'h8000_0000;
    tick();                       // E0
    inValid    = 1'b0;
    tick();                       // E1
    inValid    = 1'b1;
    widthSel   = 2'b10;
    inWord     = 32'h0000_0000;
    tick();                       // E2
    inValid    = 1'b0;
    tick();                       // E3
    tick();                       // E4
    tick();                       // E5: both at tap
    coreResult = 32'h0000_0001;
    tick();                       // E6
    coreResult = IDLE_CORE;
    check("R10 collision older wins", resultWord, 32'h8000_0001);
    check("R10 collision valid", {31'd0, outValid}, 32'd1);
    tick();
    check("R10 collision single output", {31'd0, outValid}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule